// File: doc/BRIEF.md
# TDM Timeslot Payload Extractor

This block sits behind a framer on an E1 or T1 receive path. It takes a serial line stream that is already frame-aligned, tracks the bit position inside each frame, and gathers the bytes of the selected timeslots into a byte stream for a packet builder downstream. It removes framing overhead and reserved timeslots according to the line mode. In T1 56 kbit/s operation it also splits the robbed signalling bit of each selected timeslot out onto its own output.

A single bit enable qualifies each serial bit, so the line rate can be any fraction of the system clock. A frame-start pulse, given with the enable on the first bit of a frame, sets the position counters back to zero. The timeslot mask picks which timeslots are forwarded. Bit n of the mask belongs to timeslot n.

Top module: `tdm_slot_extract`

## Requirements
- R1: In T1 mode (`mode_t1`=1) a frame is 193 bits: one framing bit first, then 24 timeslots of 8 bits. The framing bit never reaches `byte_data`. Without a new frame-start pulse, the position counter wraps to the framing bit after bit 192.
- R2: In E1 mode (`mode_t1`=0) a frame is 256 bits, made of 32 timeslots of 8 bits. Timeslot 0 is never forwarded, whatever mask bit 0 holds.
- R3: In E1 mode with `pcm30`=0, timeslot 16 is forwarded when mask bit 16 is set.
- R4: In E1 mode with `pcm30`=1, timeslot 16 is never forwarded.
- R5: Bits arrive MSB first. Each forwarded byte in T1 64 kbit/s mode (`rate56`=0) and in E1 mode carries all 8 line bits, with the first received bit at `byte_data[7]`.
- R6: In T1 mode with `rate56`=1, the last bit of each selected timeslot (the LSB) goes out on `sig_bit`, with `sig_valid` high in the same cycle as `byte_valid`. `byte_data[7:1]` holds the 7 data bits and `byte_data[0]` is 0.
- R7: `byte_sof` is high together with `byte_valid` on the first forwarded byte after each frame-start pulse, and is low on every other byte.
- R8: In T1 mode, mask bits 31 down to 24 have no effect.
- R9: A frame-start pulse in the middle of a frame restarts the bit and timeslot count at that bit. Any partly gathered byte is dropped.
- R10: After reset, `byte_valid`, `byte_sof`, `sig_valid`, `byte_data` and `sig_bit` are 0. `byte_valid` is a single-cycle pulse that comes one clock after the enabled last bit of a selected timeslot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this clock |
| bit_in | input | 1 | Serial line data bit |
| frm_start | input | 1 | First bit of a frame, valid with `bit_en` |
| mode_t1 | input | 1 | 1 = T1 line, 0 = E1 line |
| pcm30 | input | 1 | E1: reserve timeslot 16 for signalling |
| rate56 | input | 1 | T1: 56 kbit/s channels with a robbed LSB |
| slot_mask | input | 32 | Bit n selects timeslot n |
| byte_data | output | 8 | Gathered timeslot byte |
| byte_valid | output | 1 | `byte_data` is valid this cycle |
| byte_sof | output | 1 | First forwarded byte of the frame |
| sig_bit | output | 1 | Robbed signalling bit |
| sig_valid | output | 1 | `sig_bit` is valid this cycle |

## Verification
The hardest case to reach is a frame-start pulse that lands partway through a timeslot while a byte is half gathered. The old bits must vanish, with no stray byte and no slot that is off by one. The bench cuts an E1 frame short three bits into a selected timeslot and starts the next frame at once. It then checks that only the complete bytes before the cut appear, each frame with its own start marker. All stimulus uses a bit enable that is high every other clock, so the counters must hold their state between enabled bits.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int SLOT_BITS   = 8;
  localparam int IDX_W       = $clog2(SLOT_BITS);
  localparam int E1_SLOTS    = 32;
  localparam int T1_SLOTS    = 24;
  localparam int E1_FRAME    = E1_SLOTS * SLOT_BITS;
  localparam int T1_FRAME    = T1_SLOTS * SLOT_BITS + 1;
  localparam int POS_W       = $clog2(E1_FRAME);
  localparam int SLOT_W      = $clog2(E1_SLOTS);
  localparam int E1_ALIGN_TS = 0;
  localparam int E1_CAS_TS   = 16;
endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
  import tdm_pkg::*;
#(
  parameter int E1_LEN = E1_FRAME,
  parameter int T1_LEN = T1_FRAME,
  parameter int IW     = IDX_W,
  parameter int SW     = SLOT_W,
  localparam int PW    = IW + SW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          frm_start,
  input  logic          mode_t1,
  output logic [SW-1:0] slot,
  output logic [IW-1:0] bit_idx,
  output logic          is_fbit
);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] cur_pos;
  logic [PW-1:0] off;
  logic          last;

  // Position of the bit presented this cycle; a frame start forces zero.
  always_comb begin
    cur_pos = frm_start ? '0 : pos_q;
    if (mode_t1) begin
      is_fbit = (cur_pos == '0);
      off     = cur_pos - PW'(1);
      last    = (cur_pos == PW'(T1_LEN - 1));
    end else begin
      is_fbit = 1'b0;
      off     = cur_pos;
      last    = (cur_pos == PW'(E1_LEN - 1));
    end
  end

  assign slot    = off[IW +: SW];
  assign bit_idx = off[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
    end else if (bit_en) begin
      pos_q <= last ? '0 : cur_pos + PW'(1);
    end
  end

  AST_RESTART_POS: assert property (@(posedge clk) disable iff (rst)
    (bit_en && frm_start) |=> (pos_q == PW'(1)));  // R9

  AST_T1_WRAP: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !frm_start && mode_t1 && pos_q == PW'(T1_LEN - 1)) |=> (pos_q == '0));  // R1

endmodule

// File: rtl/tdm_slot_filter.sv
module tdm_slot_filter
  import tdm_pkg::*;
#(
  parameter int NSLOT  = E1_SLOTS,
  parameter int NT1    = T1_SLOTS,
  parameter int ALIGN  = E1_ALIGN_TS,
  parameter int CAS    = E1_CAS_TS,
  localparam int SW    = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_t1,
  input  logic             pcm30,
  input  logic [NSLOT-1:0] slot_mask,
  input  logic [SW-1:0]    slot,
  input  logic             is_fbit,
  output logic             sel
);

  logic [NSLOT-1:0] allow;

  // One gate per timeslot; the reserved positions are fixed by generate.
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (g == ALIGN) begin : g_align
      assign allow[g] = mode_t1 && slot_mask[g];
    end else if (g == CAS) begin : g_cas
      assign allow[g] = slot_mask[g] && (mode_t1 || !pcm30);
    end else if (g >= NT1) begin : g_e1_only
      assign allow[g] = slot_mask[g] && !mode_t1;
    end else begin : g_plain
      assign allow[g] = slot_mask[g];
    end
  end

  assign sel = !is_fbit && allow[slot];

  AST_E1_TS0_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!mode_t1 && slot == SW'(ALIGN)) |-> !sel);  // R2

  AST_CAS_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!mode_t1 && pcm30 && slot == SW'(CAS)) |-> !sel);  // R4

  AST_T1_HIGH_MASK: assert property (@(posedge clk) disable iff (rst)
    (mode_t1 && slot >= SW'(NT1)) |-> !sel);  // R8

  AST_FBIT_DROPPED: assert property (@(posedge clk) disable iff (rst)
    is_fbit |-> !sel);  // R1

endmodule

// File: rtl/tdm_byte_packer.sv
module tdm_byte_packer
  import tdm_pkg::*;
#(
  parameter int BW = SLOT_BITS,
  localparam int IW = $clog2(BW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_en,
  input  logic          bit_in,
  input  logic          frm_start,
  input  logic [IW-1:0] bit_idx,
  input  logic          is_fbit,
  input  logic          sel,
  input  logic          rob,
  output logic [BW-1:0] byte_data,
  output logic          byte_valid,
  output logic          byte_sof,
  output logic          sig_bit,
  output logic          sig_valid
);

  logic [BW-2:0] sh_q;
  logic          done;
  logic          sof_pend;

  assign done = bit_en && sel && (bit_idx == IW'(BW - 1));

  // Only the first BW-1 bits are stored; the last one is taken live.
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
    end else if (bit_en && !is_fbit) begin
      sh_q <= {sh_q[BW-3:0], bit_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sof_pend <= 1'b0;
    end else if (bit_en && frm_start) begin
      sof_pend <= 1'b1;
    end else if (done) begin
      sof_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_data  <= '0;
      byte_valid <= 1'b0;
      byte_sof   <= 1'b0;
      sig_bit    <= 1'b0;
      sig_valid  <= 1'b0;
    end else begin
      byte_valid <= done;
      byte_sof   <= done && sof_pend;
      sig_valid  <= done && rob;
      if (done) begin
        byte_data <= rob ? {sh_q, 1'b0} : {sh_q, bit_in};
        if (rob) sig_bit <= bit_in;
      end
    end
  end

  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    byte_sof |-> byte_valid);  // R7

  AST_SIG_WITH_BYTE: assert property (@(posedge clk) disable iff (rst)
    sig_valid |-> byte_valid);  // R6

  AST_SIG_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    sig_valid |-> (byte_data[0] == 1'b0));  // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_valid |=> !byte_valid);  // R10

endmodule

// File: rtl/tdm_slot_extract.sv
module tdm_slot_extract
  import tdm_pkg::*;
#(
  parameter int NSLOT = E1_SLOTS,
  parameter int BW    = SLOT_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             bit_in,
  input  logic             frm_start,
  input  logic             mode_t1,
  input  logic             pcm30,
  input  logic             rate56,
  input  logic [NSLOT-1:0] slot_mask,
  output logic [BW-1:0]    byte_data,
  output logic             byte_valid,
  output logic             byte_sof,
  output logic             sig_bit,
  output logic             sig_valid
);

  localparam int IW = $clog2(BW);
  localparam int SW = $clog2(NSLOT);

  logic [SW-1:0] slot;
  logic [IW-1:0] bit_idx;
  logic          is_fbit;
  logic          sel;
  logic          rob;

  assign rob = mode_t1 && rate56;

  tdm_frame_counter #(
    .E1_LEN (NSLOT * BW),
    .T1_LEN (T1_SLOTS * BW + 1),
    .IW     (IW),
    .SW     (SW)
  ) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .frm_start (frm_start),
    .mode_t1   (mode_t1),
    .slot      (slot),
    .bit_idx   (bit_idx),
    .is_fbit   (is_fbit)
  );

  tdm_slot_filter #(
    .NSLOT (NSLOT),
    .NT1   (T1_SLOTS),
    .ALIGN (E1_ALIGN_TS),
    .CAS   (E1_CAS_TS)
  ) u_flt (
    .clk       (clk),
    .rst       (rst),
    .mode_t1   (mode_t1),
    .pcm30     (pcm30),
    .slot_mask (slot_mask),
    .slot      (slot),
    .is_fbit   (is_fbit),
    .sel       (sel)
  );

  tdm_byte_packer #(
    .BW (BW)
  ) u_pack (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .bit_in     (bit_in),
    .frm_start  (frm_start),
    .bit_idx    (bit_idx),
    .is_fbit    (is_fbit),
    .sel        (sel),
    .rob        (rob),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_sof   (byte_sof),
    .sig_bit    (sig_bit),
    .sig_valid  (sig_valid)
  );

  AST_E1_NO_SIG: assert property (@(posedge clk) disable iff (rst)
    ($past(!mode_t1) && !mode_t1) |-> !sig_valid);  // R6

endmodule

// File: tb/tb_tdm_slot_extract.sv
`timescale 1ns/1ps
module tb_tdm_slot_extract;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bit_en = 1'b0;
  logic        bit_in = 1'b0;
  logic        frm_start = 1'b0;
  logic        mode_t1 = 1'b0;
  logic        pcm30 = 1'b0;
  logic        rate56 = 1'b0;
  logic [31:0] slot_mask = '0;
  logic [7:0]  byte_data;
  logic        byte_valid;
  logic        byte_sof;
  logic        sig_bit;
  logic        sig_valid;

  always #4 clk = ~clk;

  tdm_slot_extract dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .frm_start(frm_start), .mode_t1(mode_t1), .pcm30(pcm30),
    .rate56(rate56), .slot_mask(slot_mask), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_sof(byte_sof), .sig_bit(sig_bit),
    .sig_valid(sig_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] cap_data [0:127];
  logic       cap_sof  [0:127];
  logic       cap_sig  [0:127];
  logic       cap_sigv [0:127];
  int         cap_n = 0;

  logic [7:0] ex_data [0:127];
  logic       ex_sof  [0:127];
  logic       ex_sig  [0:127];
  logic       ex_sigv [0:127];
  int         ex_n = 0;

  always @(negedge clk) begin
    if (!rst && byte_valid && cap_n < 128) begin
      cap_data[cap_n] = byte_data;
      cap_sof[cap_n]  = byte_sof;
      cap_sig[cap_n]  = sig_bit;
      cap_sigv[cap_n] = sig_valid;
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int s);
    return 8'((s * 37 + f * 11 + 90) % 256);
  endfunction

  function automatic bit picked(input bit t1, input bit pcm, input logic [31:0] m, input int s);
    if (t1) return (s < 24) && m[s];
    return (s != 0) && !(pcm && s == 16) && m[s];
  endfunction

  task automatic send_bit(input logic b, input logic fs);
    @(negedge clk);
    bit_in = b; frm_start = fs; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; frm_start = 1'b0;
  endtask

  task automatic send_frame(input bit t1, input int f, input int nbits);
    int total = t1 ? 193 : 256;
    for (int i = 0; i < total && i < nbits; i++) begin
      logic b;
      if (t1 && i == 0) b = 1'b1;
      else begin
        int off = t1 ? i - 1 : i;
        logic [7:0] v = pat(f, off / 8);
        b = v[7 - (off % 8)];
      end
      send_bit(b, i == 0);
    end
  endtask

  task automatic add_frame(input bit t1, input bit pcm, input bit r56,
                           input logic [31:0] m, input int f, input int nslots);
    bit first = 1;
    for (int s = 0; s < nslots; s++) begin
      if (picked(t1, pcm, m, s)) begin
        logic [7:0] v = pat(f, s);
        ex_data[ex_n] = (t1 && r56) ? {v[7:1], 1'b0} : v;
        ex_sof[ex_n]  = first;
        ex_sigv[ex_n] = t1 && r56;
        ex_sig[ex_n]  = v[0];
        first = 0;
        ex_n++;
      end
    end
  endtask

  task automatic clear_lists();
    cap_n = 0; ex_n = 0;
  endtask

  task automatic compare(input string req);
    repeat (4) @(negedge clk);
    chk(cap_n == ex_n, {req, " byte count"}, cap_n, ex_n);
    for (int i = 0; i < ex_n && i < cap_n; i++) begin
      chk(cap_data[i] == ex_data[i], {req, " data"}, cap_data[i], ex_data[i]);
      chk(cap_sof[i] == ex_sof[i], {req, " R7 sof"}, cap_sof[i], ex_sof[i]);
      chk(cap_sigv[i] == ex_sigv[i], {req, " sig_valid"}, cap_sigv[i], ex_sigv[i]);
      if (ex_sigv[i])
        chk(cap_sig[i] == ex_sig[i], {req, " sig_bit"}, cap_sig[i], ex_sig[i]);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(byte_valid == 0 && byte_sof == 0 && sig_valid == 0, "R10 reset flags",
        {byte_valid, byte_sof, sig_valid}, 0);
    chk(byte_data == 0 && sig_bit == 0, "R10 reset data", {byte_data, sig_bit}, 0);
  endtask

  task automatic t_e1_all();
    clear_lists();
    mode_t1 = 0; pcm30 = 0; rate56 = 1; slot_mask = 32'hFFFF_FFFF;
    send_frame(0, 1, 256);
    add_frame(0, 0, 0, slot_mask, 1, 32);
    compare("R2 R3 R5 e1 full mask");
  endtask

  task automatic t_e1_pcm30();
    clear_lists();
    mode_t1 = 0; pcm30 = 1; rate56 = 0; slot_mask = 32'hFFFF_FFFF;
    send_frame(0, 2, 256);
    add_frame(0, 1, 0, slot_mask, 2, 32);
    compare("R4 e1 pcm30");
  endtask

  task automatic t_t1_64k();
    clear_lists();
    mode_t1 = 1; pcm30 = 1; rate56 = 0; slot_mask = 32'h00FF_FFFF;
    send_frame(1, 5, 193);
    send_frame(1, 6, 193);
    add_frame(1, 0, 0, slot_mask, 5, 24);
    add_frame(1, 0, 0, slot_mask, 6, 24);
    compare("R1 R5 R7 t1 64k");
  endtask

  task automatic t_t1_56k();
    clear_lists();
    mode_t1 = 1; pcm30 = 0; rate56 = 1; slot_mask = 32'h0000_0421;
    send_frame(1, 7, 193);
    add_frame(1, 0, 1, slot_mask, 7, 24);
    compare("R6 t1 56k");
  endtask

  task automatic t_t1_high_mask();
    clear_lists();
    mode_t1 = 1; pcm30 = 0; rate56 = 0; slot_mask = 32'hFF00_0002;
    send_frame(1, 8, 193);
    add_frame(1, 0, 0, slot_mask, 8, 24);
    compare("R8 t1 high mask");
  endtask

  task automatic t_midframe();
    clear_lists();
    mode_t1 = 0; pcm30 = 0; rate56 = 0; slot_mask = 32'h0000_000A;
    send_frame(0, 3, 27);
    send_frame(0, 4, 256);
    add_frame(0, 0, 0, slot_mask, 3, 3);
    add_frame(0, 0, 0, slot_mask, 4, 32);
    compare("R9 mid-frame restart");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_e1_all();
    t_e1_pcm30();
    t_t1_64k();
    t_t1_56k();
    t_t1_high_mask();
    t_midframe();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule